// File: doc/BRIEF.md
# Two-Wire Bus Byte Engine (Master Side)

This block is the bit-level engine of an I2C-style two-wire master. It moves one byte at a time over open-drain SCL and SDA lines, puts START, repeated START and STOP conditions on the bus, and watches the bus for those conditions from any source. A separate control unit drives it with single-cycle command pulses and a bit-timing strobe (`tick`, four strobes per bit). It returns single-cycle event pulses: byte finished, condition finished, arbitration lost, START seen and STOP seen. Address matching, status coding and baud generation belong to that control unit.

Each line has a drive-low enable output and a sampled input. Both inputs pass through a two-flop synchronizer before any decision is made on them. One 8-bit shift register carries the outgoing byte and collects the bus bits, most significant first. A separate one-bit acknowledge register holds the acknowledge to send on a read or the acknowledge received on a write. It is only visible through `ack_rx`.

The controller has these states. `ST_IDLE`: both lines released. `ST_START_SETUP`: SCL low, SDA released. `ST_START_RISE`: both lines released, waiting for SCL. `ST_START_LOW`: SDA low with SCL high. `ST_START_FALL`: both lines low. `ST_HOLD`: SCL held low, waiting for the next command. `ST_BIT_LO`, `ST_BIT_RISE`, `ST_BIT_HI`, `ST_BIT_FALL`: the four phases of each bit. `ST_STOP_SETUP`, `ST_STOP_RISE`, `ST_STOP_REL`: the STOP sequence.

Transitions:
- IDLE→START_RISE on a start command.
- HOLD→START_SETUP on a start command, HOLD→STOP_SETUP on a stop command, and HOLD→BIT_LO on a write or read command.
- START_SETUP→START_RISE, START_LOW→START_FALL and START_FALL→HOLD on a tick.
- START_RISE→START_LOW on a tick once SCL is sampled high.
- BIT_LO→BIT_RISE and BIT_HI→BIT_FALL on a tick.
- BIT_RISE→BIT_HI on a tick once SCL is sampled high.
- BIT_FALL→BIT_LO on a tick for bits 0 to 7. For the ninth bit it goes to HOLD, or to IDLE if arbitration was lost.
- STOP_SETUP→STOP_RISE on a tick, STOP_RISE→STOP_REL on a tick once SCL is high, and STOP_REL→IDLE on a tick.

Top module: `tw_byte_engine`

## Requirements
- R1: After reset, neither line is driven low, `busy` is 0, `rx_byte` is 0x00 and `ack_rx` is 1.
- R2: A start command in the idle state pulls SDA low while SCL is high, then pulls SCL low and pulses `cond_done`.
- R3: A write command sends `tx_byte` most significant bit first in eight SCL clocks, followed by a ninth acknowledge clock with SDA released. It then pulses `byte_done` once, and `rx_byte` holds the eight bits seen on the bus.
- R4: After a START or a byte, SCL stays driven low (state `ST_HOLD`) until the next command.
- R5: During a byte, SDA changes only while SCL is low, so no START or STOP appears on the bus.
- R6: On a write, the SDA level sampled in the ninth clock is stored in the acknowledge register and shown on `ack_rx` (0 = acknowledge, 1 = not acknowledge).
- R7: A read command releases SDA for eight clocks and shifts the sampled bits into `rx_byte`, most significant bit first. In the ninth clock it pulls SDA low if `ack_send` is 0 and releases it if `ack_send` is 1. `ack_rx` then shows `ack_send`.
- R8: If a write bit is released high but SDA is sampled low, `arb_lost` pulses and SDA is not driven again for the rest of the byte. The byte is still clocked to its end, `rx_byte` holds the bus byte, and the engine returns to idle with both lines released.
- R9: A falling SDA while SCL is high pulses `start_seen`, and a rising SDA while SCL is high pulses `stop_seen`. This holds whoever drives the bus, and the engine does not react to these events on its own.
- R10: A stop command in the hold state pulls SDA low while SCL is low, releases SCL, then releases SDA. It pulses `cond_done` and ends idle with both lines released.
- R11: A start command in the hold state produces a repeated START with no STOP before it.
- R12: Commands are taken only in `ST_IDLE` (start only) or `ST_HOLD`. In the hold state, if several commands arrive together, start wins over stop, stop over write and write over read. Any other command is ignored.
- R13: The engine waits in a rising phase for as long as another device holds SCL low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Bit-timing strobe, one phase per pulse |
| cmd_start | input | 1 | Start or repeated-start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| cmd_write | input | 1 | Send-byte command pulse |
| cmd_read | input | 1 | Receive-byte command pulse |
| tx_byte | input | 8 | Byte to send, taken with cmd_write |
| ack_send | input | 1 | Acknowledge to send after a read, taken with cmd_read |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | A command sequence is running |
| byte_done | output | 1 | Pulse: byte and acknowledge clock finished |
| cond_done | output | 1 | Pulse: START or STOP sequence finished |
| arb_lost | output | 1 | Pulse: arbitration lost on a write bit |
| ack_rx | output | 1 | Content of the acknowledge register |
| rx_byte | output | 8 | Shift register content, the bus byte |
| start_seen | output | 1 | Pulse: START detected on the bus |
| stop_seen | output | 1 | Pulse: STOP detected on the bus |

## Verification
If the bit counter or the phase state goes wrong, the bus model gets the wrong number of clocks or sees SDA move while SCL is high. The first shows up as a wrong captured byte or a missing `byte_done` within one byte time (about 150 cycles at four clocks per tick). The second shows up as a spurious `start_seen` or `stop_seen` within three cycles of the bad edge. A wrong acknowledge register or arbitration flag shows on `ack_rx`, `arb_lost`, or on the byte captured by the bus model, at the end of the byte concerned. A wrong command decode shows up as a missing or extra `cond_done` or `byte_done`, or as SCL released while it should be held.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START_SETUP,
        ST_START_RISE,
        ST_START_LOW,
        ST_START_FALL,
        ST_HOLD,
        ST_BIT_LO,
        ST_BIT_RISE,
        ST_BIT_HI,
        ST_BIT_FALL,
        ST_STOP_SETUP,
        ST_STOP_RISE,
        ST_STOP_REL
    } tw_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_START,
        OP_STOP,
        OP_WRITE,
        OP_READ
    } tw_op_e;

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Lines idle high, so every stage resets to one.
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_det,
    output logic stop_det
);

    logic scl_prev;
    logic sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    // SDA edge while SCL stays high on both samples
    assign start_det = scl_s && scl_prev && sda_prev && !sda_s;
    assign stop_det  = scl_s && scl_prev && !sda_prev && sda_s;

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !start_det); // R9

    AST_STOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !stop_det); // R9

endmodule

// File: rtl/tw_bit_ctrl.sv
module tw_bit_ctrl
    import tw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_write,
    input  logic              cmd_read,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              ack_send,
    input  logic              scl_s,
    input  logic              sda_s,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    output logic              busy,
    output logic              byte_done,
    output logic              cond_done,
    output logic              arb_lost,
    output logic              ack_rx,
    output logic [DATA_W-1:0] rx_byte
);

    localparam int              CNT_W    = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DATA_W);

    tw_state_e         state;
    tw_state_e         state_nxt;
    tw_op_e            op;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              ack_q;
    logic              rd_mode;
    logic              lost;
    logic              samp_q;
    logic              last_bit;
    logic              bit_pull;

    assign last_bit = (bit_cnt == ACK_SLOT);

    // Command decode: idle takes only start; hold takes all, in priority order
    always_comb begin
        op = OP_NONE;
        if (state == ST_IDLE) begin
            if (cmd_start) op = OP_START;
        end else if (state == ST_HOLD) begin
            if (cmd_start)      op = OP_START;
            else if (cmd_stop)  op = OP_STOP;
            else if (cmd_write) op = OP_WRITE;
            else if (cmd_read)  op = OP_READ;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (op == OP_START) state_nxt = ST_START_RISE;
            end
            ST_HOLD: begin
                unique case (op)
                    OP_START:          state_nxt = ST_START_SETUP;
                    OP_STOP:           state_nxt = ST_STOP_SETUP;
                    OP_WRITE, OP_READ: state_nxt = ST_BIT_LO;
                    default:           state_nxt = ST_HOLD;
                endcase
            end
            ST_START_SETUP: if (tick)          state_nxt = ST_START_RISE;
            ST_START_RISE:  if (tick && scl_s) state_nxt = ST_START_LOW;
            ST_START_LOW:   if (tick)          state_nxt = ST_START_FALL;
            ST_START_FALL:  if (tick)          state_nxt = ST_HOLD;
            ST_BIT_LO:      if (tick)          state_nxt = ST_BIT_RISE;
            ST_BIT_RISE:    if (tick && scl_s) state_nxt = ST_BIT_HI;
            ST_BIT_HI:      if (tick)          state_nxt = ST_BIT_FALL;
            ST_BIT_FALL: begin
                if (tick) begin
                    if (!last_bit) state_nxt = ST_BIT_LO;
                    else if (lost) state_nxt = ST_IDLE;
                    else           state_nxt = ST_HOLD;
                end
            end
            ST_STOP_SETUP:  if (tick)          state_nxt = ST_STOP_SETUP == state ? ST_STOP_RISE : state;
            ST_STOP_RISE:   if (tick && scl_s) state_nxt = ST_STOP_REL;
            ST_STOP_REL:    if (tick)          state_nxt = ST_IDLE;
            default:                           state_nxt = ST_IDLE;
        endcase
    end

    // SDA level wanted during the four phases of the current bit
    always_comb begin
        if (lost)          bit_pull = 1'b0;
        else if (last_bit) bit_pull = rd_mode && !ack_q;
        else               bit_pull = !rd_mode && !shreg[DATA_W-1];
    end

    // Line drivers and busy, decoded from the state
    always_comb begin
        scl_drive_low = 1'b0;
        sda_drive_low = 1'b0;
        busy          = 1'b1;
        unique case (state)
            ST_IDLE:        busy = 1'b0;
            ST_HOLD: begin
                busy          = 1'b0;
                scl_drive_low = 1'b1;
            end
            ST_START_SETUP: scl_drive_low = 1'b1;
            ST_START_RISE:  scl_drive_low = 1'b0;
            ST_START_LOW:   sda_drive_low = 1'b1;
            ST_START_FALL: begin
                scl_drive_low = 1'b1;
                sda_drive_low = 1'b1;
            end
            ST_BIT_LO, ST_BIT_FALL: begin
                scl_drive_low = 1'b1;
                sda_drive_low = bit_pull;
            end
            ST_BIT_RISE, ST_BIT_HI: sda_drive_low = bit_pull;
            ST_STOP_SETUP: begin
                scl_drive_low = 1'b1;
                sda_drive_low = 1'b1;
            end
            ST_STOP_RISE:   sda_drive_low = 1'b1;
            ST_STOP_REL:    sda_drive_low = 1'b0;
            default:        busy = 1'b0;
        endcase
    end

    // Shift register, acknowledge register, bit counter and event pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bit_cnt   <= '0;
            ack_q     <= 1'b1;
            rd_mode   <= 1'b0;
            lost      <= 1'b0;
            samp_q    <= 1'b1;
            byte_done <= 1'b0;
            cond_done <= 1'b0;
            arb_lost  <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            cond_done <= 1'b0;
            arb_lost  <= 1'b0;

            if (op == OP_WRITE) begin
                shreg   <= tx_byte;
                rd_mode <= 1'b0;
                lost    <= 1'b0;
                bit_cnt <= '0;
            end
            if (op == OP_READ) begin
                rd_mode <= 1'b1;
                ack_q   <= ack_send;
                lost    <= 1'b0;
                bit_cnt <= '0;
            end

            // Sample at the high phase; compare a released bit against the bus
            if (tick && state == ST_BIT_HI) begin
                samp_q <= sda_s;
                if (!rd_mode && !last_bit && !lost && shreg[DATA_W-1] && !sda_s) begin
                    lost     <= 1'b1;
                    arb_lost <= 1'b1;
                end
            end

            // Shift only once SCL is low again, so SDA never moves while high
            if (tick && state == ST_BIT_FALL) begin
                if (last_bit) begin
                    bit_cnt   <= '0;
                    byte_done <= 1'b1;
                    if (!rd_mode) ack_q <= samp_q;
                end else begin
                    shreg   <= {shreg[DATA_W-2:0], samp_q};
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
            end

            if (tick && (state == ST_START_FALL || state == ST_STOP_REL)) begin
                cond_done <= 1'b1;
            end
        end
    end

    assign ack_rx  = ack_q;
    assign rx_byte = shreg;

    AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIT_HI && $past(state) == ST_BIT_HI) |-> $stable(sda_drive_low)); // R5

    AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> !sda_drive_low); // R8

    AST_STRETCH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIT_RISE && !scl_s) |=> (state == ST_BIT_RISE)); // R13

    AST_HOLD_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !cmd_start && !cmd_stop && !cmd_write && !cmd_read) |=> scl_drive_low); // R4

    AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done); // R3

    AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({byte_done, cond_done, arb_lost})); // R12

endmodule

// File: rtl/tw_byte_engine.sv
module tw_byte_engine #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_write,
    input  logic              cmd_read,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              ack_send,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    output logic              busy,
    output logic              byte_done,
    output logic              cond_done,
    output logic              arb_lost,
    output logic              ack_rx,
    output logic [DATA_W-1:0] rx_byte,
    output logic              start_seen,
    output logic              stop_seen
);

    logic [1:0] lines_s;
    logic       scl_s;
    logic       sda_s;

    tw_line_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     (lines_s)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    tw_cond_detect u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .start_det (start_seen),
        .stop_det  (stop_seen)
    );

    tw_bit_ctrl #(
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .cmd_start     (cmd_start),
        .cmd_stop      (cmd_stop),
        .cmd_write     (cmd_write),
        .cmd_read      (cmd_read),
        .tx_byte       (tx_byte),
        .ack_send      (ack_send),
        .scl_s         (scl_s),
        .sda_s         (sda_s),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .busy          (busy),
        .byte_done     (byte_done),
        .cond_done     (cond_done),
        .arb_lost      (arb_lost),
        .ack_rx        (ack_rx),
        .rx_byte       (rx_byte)
    );

endmodule

// File: tb/tb_tw_byte_engine.sv
module tb_tw_byte_engine;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic       cmd_start, cmd_stop, cmd_write, cmd_read;
    logic [7:0] tx_byte;
    logic       ack_send;
    logic       scl_drive_low, sda_drive_low;
    logic       busy, byte_done, cond_done, arb_lost, ack_rx;
    logic [7:0] rx_byte;
    logic       start_seen, stop_seen;

    // Bench-side open-drain drivers
    logic tb_scl_low;
    logic man_sda_low;
    logic s_sda_low;
    logic scl_bus, sda_bus;

    assign scl_bus = !(scl_drive_low || tb_scl_low);
    assign sda_bus = !(sda_drive_low || man_sda_low || s_sda_low);

    always #2 clk = ~clk;

    tw_byte_engine dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .cmd_start     (cmd_start),
        .cmd_stop      (cmd_stop),
        .cmd_write     (cmd_write),
        .cmd_read      (cmd_read),
        .tx_byte       (tx_byte),
        .ack_send      (ack_send),
        .scl_in        (scl_bus),
        .sda_in        (sda_bus),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .busy          (busy),
        .byte_done     (byte_done),
        .cond_done     (cond_done),
        .arb_lost      (arb_lost),
        .ack_rx        (ack_rx),
        .rx_byte       (rx_byte),
        .start_seen    (start_seen),
        .stop_seen     (stop_seen)
    );

    int n_checks = 0;
    int n_err    = 0;
    int n_byte = 0, n_cond = 0, n_arb = 0, n_start = 0, n_stop = 0;

    // Bus device model: 0 silent, 1 acknowledges writes, 2 serves reads, 3 competing master
    int         s_mode = 0;
    logic [7:0] s_tx = 8'h00;
    logic [7:0] s_rx = 8'h00;
    int         s_cnt = 0;
    bit         s_first = 1'b0;
    bit         s_nack = 1'b0;
    bit         s_ackbit = 1'b1;
    bit         prev_scl = 1'b1;
    bit         prev_sda = 1'b1;

    initial s_sda_low = 1'b0;

    always @(negedge clk) begin
        if (scl_bus && prev_scl && prev_sda && !sda_bus) begin
            s_cnt   = 0;
            s_first = 1'b1;
            s_nack  = 1'b0;
        end else if (prev_scl && !scl_bus) begin
            if (s_first)         s_first = 1'b0;
            else if (s_cnt == 8) s_cnt = 0;
            else                 s_cnt++;
            s_sda_low = 1'b0;
            if (s_mode == 1 && s_cnt == 8)              s_sda_low = 1'b1;
            if (s_mode == 2 && s_cnt < 8 && !s_nack)    s_sda_low = !s_tx[7-s_cnt];
            if (s_mode == 3 && s_cnt < 8)               s_sda_low = !s_tx[7-s_cnt];
        end else if (!prev_scl && scl_bus) begin
            if (s_cnt < 8) begin
                s_rx = {s_rx[6:0], sda_bus};
            end else begin
                s_ackbit = sda_bus;
                if (s_mode == 2 && sda_bus) s_nack = 1'b1;
            end
        end
        prev_scl = scl_bus;
        prev_sda = sda_bus;
    end

    // Event counters
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_done)  n_byte++;
            if (cond_done)  n_cond++;
            if (arb_lost)   n_arb++;
            if (start_seen) n_start++;
            if (stop_seen)  n_stop++;
        end
    end

    // Bit-timing strobe: one of every four cycles
    initial begin
        tick = 1'b0;
        for (int k = 1; k < 1000000; k++) begin
            @(negedge clk);
            tick = (k % 4 == 0);
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_cmd(input logic s, input logic p, input logic w, input logic r,
                            input logic [7:0] d, input logic a);
        @(negedge clk);
        cmd_start = s; cmd_stop = p; cmd_write = w; cmd_read = r;
        tx_byte = d; ack_send = a;
        @(negedge clk);
        cmd_start = 1'b0; cmd_stop = 1'b0; cmd_write = 1'b0; cmd_read = 1'b0;
    endtask

    function automatic int evt_count(input int which);
        case (which)
            0:       return n_byte;
            1:       return n_cond;
            default: return n_arb;
        endcase
    endfunction

    task automatic wait_evt(input int which, input int base, input string req);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (evt_count(which) != base) return;
        end
        check(req, "event timeout", evt_count(which), base + 1);
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1", "scl_drive_low", scl_drive_low, 0);
        check("R1", "sda_drive_low", sda_drive_low, 0);
        check("R1", "busy", busy, 0);
        check("R1", "rx_byte", rx_byte, 8'h00);
        check("R1", "ack_rx", ack_rx, 1);
    endtask

    task automatic t_ignore_idle;
        int b = n_byte;
        send_cmd(1'b0, 1'b1, 1'b1, 1'b1, 8'h33, 1'b0);
        idle_cycles(40);
        check("R12", "busy after write in idle", busy, 0);
        check("R12", "scl held in idle", scl_drive_low, 0);
        check("R12", "byte_done count", n_byte, b);
    endtask

    task automatic t_start;
        int c = n_cond;
        int st = n_start;
        send_cmd(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        wait_evt(1, c, "R2");
        idle_cycles(2);
        check("R2", "start seen on bus", n_start, st + 1);
        check("R2", "busy after start", busy, 0);
        idle_cycles(20);
        check("R4", "scl held low after start", scl_drive_low, 1);
    endtask

    task automatic t_write_ack;
        int b = n_byte;
        int c = n_cond;
        int st = n_start;
        int sp = n_stop;
        s_mode = 1;
        send_cmd(1'b0, 1'b0, 1'b1, 1'b0, 8'hC6, 1'b0);
        idle_cycles(30);
        // commands while busy must be dropped
        send_cmd(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
        wait_evt(0, b, "R3");
        idle_cycles(40);
        check("R3", "bus byte", s_rx, 8'hC6);
        check("R3", "rx_byte", rx_byte, 8'hC6);
        check("R6", "ack_rx on ack", ack_rx, 0);
        check("R12", "busy-time commands dropped (bytes)", n_byte, b + 1);
        check("R12", "busy-time commands dropped (conds)", n_cond, c);
        check("R5", "no start during byte", n_start, st);
        check("R5", "no stop during byte", n_stop, sp);
        check("R4", "scl held after byte", scl_drive_low, 1);
    endtask

    task automatic t_write_nack;
        int b = n_byte;
        s_mode = 0;
        send_cmd(1'b0, 1'b0, 1'b1, 1'b0, 8'h5B, 1'b0);
        wait_evt(0, b, "R6");
        idle_cycles(2);
        check("R6", "bus byte", s_rx, 8'h5B);
        check("R6", "ack_rx on nack", ack_rx, 1);
    endtask

    task automatic t_stretch;
        int b = n_byte;
        s_mode = 1;
        @(negedge clk);
        tb_scl_low = 1'b1;
        send_cmd(1'b0, 1'b0, 1'b1, 1'b0, 8'h81, 1'b0);
        idle_cycles(200);
        check("R13", "no byte while stretched", n_byte, b);
        check("R13", "busy while stretched", busy, 1);
        check("R13", "scl released while waiting", scl_drive_low, 0);
        tb_scl_low = 1'b0;
        wait_evt(0, b, "R13");
        idle_cycles(2);
        check("R13", "bus byte after stretch", s_rx, 8'h81);
    endtask

    task automatic t_rep_start;
        int c = n_cond;
        int st = n_start;
        int sp = n_stop;
        s_mode = 2;
        s_tx = 8'h3C;
        send_cmd(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        wait_evt(1, c, "R11");
        idle_cycles(2);
        check("R11", "repeated start seen", n_start, st + 1);
        check("R11", "no stop before it", n_stop, sp);
    endtask

    task automatic t_read;
        int b = n_byte;
        send_cmd(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
        wait_evt(0, b, "R7");
        idle_cycles(2);
        check("R7", "first read byte", rx_byte, 8'h3C);
        check("R7", "ack driven low", s_ackbit, 0);
        check("R7", "ack_rx holds ack to send", ack_rx, 0);
        s_tx = 8'h5A;
        b = n_byte;
        send_cmd(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1);
        wait_evt(0, b, "R7");
        idle_cycles(2);
        check("R7", "second read byte", rx_byte, 8'h5A);
        check("R7", "nack released", s_ackbit, 1);
    endtask

    task automatic t_stop;
        int c = n_cond;
        int sp = n_stop;
        s_mode = 0;
        send_cmd(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        wait_evt(1, c, "R10");
        idle_cycles(4);
        check("R10", "stop seen", n_stop, sp + 1);
        check("R10", "busy", busy, 0);
        check("R10", "scl released", scl_bus, 1);
        check("R10", "sda released", sda_bus, 1);
    endtask

    task automatic t_arb;
        int c = n_cond;
        int a = n_arb;
        int b;
        s_mode = 3;
        s_tx = 8'hA1;
        send_cmd(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        wait_evt(1, c, "R8");
        b = n_byte;
        send_cmd(1'b0, 1'b0, 1'b1, 1'b0, 8'hA4, 1'b0);
        wait_evt(0, b, "R8");
        idle_cycles(4);
        check("R8", "arb_lost pulses", n_arb, a + 1);
        check("R8", "rx_byte is bus byte", rx_byte, 8'hA1);
        check("R8", "idle after loss", busy, 0);
        check("R8", "scl released after loss", scl_drive_low, 0);
        check("R8", "sda released after loss", sda_drive_low, 0);
        s_mode = 0;
    endtask

    task automatic t_bus_cond;
        int st = n_start;
        int sp = n_stop;
        int c = n_cond;
        idle_cycles(10);
        man_sda_low = 1'b1;
        idle_cycles(10);
        check("R9", "foreign start seen", n_start, st + 1);
        man_sda_low = 1'b0;
        idle_cycles(10);
        check("R9", "foreign stop seen", n_stop, sp + 1);
        check("R9", "engine stays idle", busy, 0);
        check("R9", "no cond_done", n_cond, c);
    endtask

    task automatic t_priority;
        int c = n_cond;
        int st;
        int sp;
        int b;
        send_cmd(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        wait_evt(1, c, "R12");
        idle_cycles(8);
        c = n_cond; st = n_start; sp = n_stop;
        send_cmd(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        wait_evt(1, c, "R12");
        idle_cycles(2);
        check("R12", "start beats stop (start)", n_start, st + 1);
        check("R12", "start beats stop (stop)", n_stop, sp);
        c = n_cond; sp = n_stop; b = n_byte;
        send_cmd(1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, 1'b0);
        wait_evt(1, c, "R12");
        idle_cycles(4);
        check("R12", "stop beats write (stop)", n_stop, sp + 1);
        check("R12", "stop beats write (bytes)", n_byte, b);
        check("R12", "idle after stop", busy, 0);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0;
        cmd_start = 1'b0; cmd_stop = 1'b0; cmd_write = 1'b0; cmd_read = 1'b0;
        tx_byte = 8'h00; ack_send = 1'b0;
        tb_scl_low = 1'b0; man_sda_low = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        idle_cycles(4);
        t_reset;
        t_ignore_idle;
        t_start;
        t_write_ack;
        t_write_nack;
        t_stretch;
        t_rep_start;
        t_read;
        t_stop;
        t_arb;
        t_bus_cond;
        t_priority;
        finish_run;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog (all requirements): actual expired expected finished");
        finish_run;
    end

endmodule